// File: doc/BRIEF.md
# Programmable Per-Channel Pixel Clipper

This block is one pipeline stage of a video output path. It takes a 24-bit pixel that holds three 8-bit components, together with a data-enable strobe and horizontal and vertical sync. It limits each component to its own programmable window, with a lower bound and an upper bound. The sync and enable signals pass through the same single register stage, so they stay aligned with the pixel they belong to.

The limits are held inside the block. A one-cycle load strobe captures the packed upper-bound and lower-bound words from the configuration inputs. At reset, the block fills its limits with a default set that depends on the colour-space mode input. The YCbCr set is the studio-swing range. The RGB set keeps the codes 0x00 and 0xFF free. When the mode input changes later, the block reloads the default set that matches the new mode. A full-range input turns clipping off entirely. Outside the active region the pixel output is driven to zero.

Top module: `pix_range_limiter`

## Requirements
- R1: During reset and in the first cycle after reset is released, outPix is zero and outDe, outHs and outVs are low.
- R2: outDe, outHs and outVs equal inDe, inHs and inVs delayed by exactly one clock.
- R3: With inDe high and fullRange low, a component above its upper bound is output as that upper bound one clock later. Limit words and pixels place red/Cr in bits [23:16], green/luma in bits [15:8] and blue/Cb in bits [7:0].
- R4: With inDe high and fullRange low, a component below its lower bound is output as that lower bound. A component inside its window passes unchanged.
- R5: A reset with ycbcrMode high (1 = YCbCr) sets the upper bounds to 0xF0 for Cr, 0xEB for luma and 0xF0 for Cb, and sets every lower bound to 0x10.
- R6: A reset with ycbcrMode low (0 = RGB) sets every upper bound to 0xFE and every lower bound to 0x01.
- R7: While fullRange is high and inDe is high, the pixel is output one clock later without modification.
- R8: Whenever outDe is low, outPix is zero, whatever inPix and fullRange were.
- R9: If a lower bound exceeds its upper bound, that component is output as the upper bound.
- R10: A clock edge at which ycbcrMode differs from its value at the previous edge loads the default set for the new mode. If limLoad is high at the same edge, the programmed words are loaded instead.
- R11: A clock edge with limLoad high captures maxWord and minWord. They govern pixels presented from the next cycle on. While limLoad is low, changes on maxWord and minWord have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous active-low reset |
| ycbcrMode | input | 1 | Colour-space mode, 1 = YCbCr, 0 = RGB; selects the default limits |
| fullRange | input | 1 | 1 = pass pixels without clipping |
| limLoad | input | 1 | One-cycle strobe that captures the limit words |
| maxWord | input | 24 | Packed upper bounds (R/Cr, G/Y, B/Cb) |
| minWord | input | 24 | Packed lower bounds (R/Cr, G/Y, B/Cb) |
| inPix | input | 24 | Input pixel |
| inDe | input | 1 | Input data enable |
| inHs | input | 1 | Input horizontal sync |
| inVs | input | 1 | Input vertical sync |
| outPix | output | 24 | Clipped pixel |
| outDe | output | 1 | Delayed data enable |
| outHs | output | 1 | Delayed horizontal sync |
| outVs | output | 1 | Delayed vertical sync |

## Verification
The bench uses components that sit above, below and inside their windows within a single pixel. A design with the field order swapped, or with one shared bound, would put a bound on the wrong component. An inverted window with the lower bound above the upper bound is also tested. A design that tests the upper bound before the lower bound lets the lower bound win and produces 0x80 where 0x40 is expected. A mode change is made on its own and again together with a load strobe. A design that ignores the mode change keeps the old limits. A design with the wrong priority overwrites the programmed words with defaults. The bench also changes the limit words without a strobe, and drives blanking with a non-zero pixel while full range is set. These catch a design that tracks the words continuously or leaks data outside the active region.

// File: rtl/pix_clip_pkg.sv
package pix_clip_pkg;
  parameter int COMP_W   = 8;
  parameter int NUM_COMP = 3;
  localparam int PIX_W   = COMP_W * NUM_COMP;

  typedef logic [PIX_W-1:0] pix_t;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic loadProg;  // capture the programmed limit words
    logic loadDef;   // reload the default limit set
    logic defYcc;    // which default set: 1 = YCbCr, 0 = RGB
  } clip_ctl_t;

  function automatic pix_t defaultMax(input logic ycc);
    pix_t v;
    for (int c = 0; c < NUM_COMP; c++) begin
      if (ycc) v[c*COMP_W +: COMP_W] = (c == 1) ? COMP_W'(8'hEB) : COMP_W'(8'hF0);
      else     v[c*COMP_W +: COMP_W] = COMP_W'(8'hFE);
    end
    return v;
  endfunction

  function automatic pix_t defaultMin(input logic ycc);
    pix_t v;
    for (int c = 0; c < NUM_COMP; c++)
      v[c*COMP_W +: COMP_W] = ycc ? COMP_W'(8'h10) : COMP_W'(8'h01);
    return v;
  endfunction
endpackage

// File: rtl/pix_clip_ctrl.sv
module pix_clip_ctrl
  import pix_clip_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ycbcrMode,
  input  logic      limLoad,
  output clip_ctl_t ctl
);
  logic modePrev;

  always_ff @(posedge clk) begin
    modePrev <= ycbcrMode;
  end

  // An explicit load beats the default reload on the same edge
  always_comb begin
    ctl.loadProg = rstN && limLoad;
    ctl.loadDef  = rstN && !limLoad && (ycbcrMode != modePrev);
    ctl.defYcc   = ycbcrMode;
  end
endmodule

// File: rtl/pix_clip_dp.sv
module pix_clip_dp
  import pix_clip_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  clip_ctl_t ctl,
  input  logic      fullRange,
  input  pix_t      maxWord,
  input  pix_t      minWord,
  input  pix_t      inPix,
  input  logic      inDe,
  input  logic      inHs,
  input  logic      inVs,
  output pix_t      outPix,
  output logic      outDe,
  output logic      outHs,
  output logic      outVs
);
  pix_t maxReg, minReg, clipped;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maxReg <= defaultMax(ctl.defYcc);
      minReg <= defaultMin(ctl.defYcc);
    end else if (ctl.loadProg) begin
      maxReg <= maxWord;
      minReg <= minWord;
    end else if (ctl.loadDef) begin
      maxReg <= defaultMax(ctl.defYcc);
      minReg <= defaultMin(ctl.defYcc);
    end
  end

  // Per-component limiter: raise to the floor first, then cap, so the cap wins
  for (genvar c = 0; c < NUM_COMP; c++) begin : gComp
    logic [COMP_W-1:0] v, lo, hi, floored;
    assign v  = inPix[c*COMP_W +: COMP_W];
    assign lo = minReg[c*COMP_W +: COMP_W];
    assign hi = maxReg[c*COMP_W +: COMP_W];
    assign floored = (v < lo) ? lo : v;
    assign clipped[c*COMP_W +: COMP_W] = (floored > hi) ? hi : floored;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPix <= '0;
      outDe  <= 1'b0;
      outHs  <= 1'b0;
      outVs  <= 1'b0;
    end else begin
      outDe  <= inDe;
      outHs  <= inHs;
      outVs  <= inVs;
      if (!inDe)          outPix <= '0;
      else if (fullRange) outPix <= inPix;
      else                outPix <= clipped;
    end
  end
endmodule

// File: rtl/pix_range_limiter.sv
module pix_range_limiter
  import pix_clip_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ycbcrMode,
  input  logic             fullRange,
  input  logic             limLoad,
  input  logic [PIX_W-1:0] maxWord,
  input  logic [PIX_W-1:0] minWord,
  input  logic [PIX_W-1:0] inPix,
  input  logic             inDe,
  input  logic             inHs,
  input  logic             inVs,
  output logic [PIX_W-1:0] outPix,
  output logic             outDe,
  output logic             outHs,
  output logic             outVs
);
  clip_ctl_t ctl;

  pix_clip_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ycbcrMode(ycbcrMode), .limLoad(limLoad), .ctl(ctl)
  );

  pix_clip_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fullRange(fullRange),
    .maxWord(maxWord), .minWord(minWord), .inPix(inPix),
    .inDe(inDe), .inHs(inHs), .inVs(inVs),
    .outPix(outPix), .outDe(outDe), .outHs(outHs), .outVs(outVs)
  );
endmodule

// File: rtl/pix_range_limiter_chk.sv
module pix_range_limiter_chk
  import pix_clip_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       fullRange,
  input logic [PIX_W-1:0] inPix,
  input logic       inDe,
  input logic       inHs,
  input logic       inVs,
  input logic [PIX_W-1:0] outPix,
  input logic       outDe,
  input logic       outHs,
  input logic       outVs
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (outPix == '0 && !outDe && !outHs && !outVs));

  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outDe == $past(inDe)) && (outHs == $past(inHs)) && (outVs == $past(inVs)));

  assert_full_range_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fullRange && inDe) |=> (outPix == $past(inPix)));

  assert_blank_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !outDe |-> (outPix == '0));
endmodule

bind pix_range_limiter pix_range_limiter_chk uChk (
  .clk(clk), .rstN(rstN), .fullRange(fullRange), .inPix(inPix),
  .inDe(inDe), .inHs(inHs), .inVs(inVs),
  .outPix(outPix), .outDe(outDe), .outHs(outHs), .outVs(outVs)
);

// File: tb/pix_range_limiter_test.sv
module pix_range_limiter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ycbcrMode = 1'b1, fullRange = 1'b0, limLoad = 1'b0;
  logic [23:0] maxWord = '0, minWord = '0, inPix = '0;
  logic inDe = 1'b0, inHs = 1'b0, inVs = 1'b0;
  logic [23:0] outPix;
  logic outDe, outHs, outVs;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  pix_range_limiter uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference limiter: floor first, then cap
  function automatic logic [23:0] ref_clip(input logic [23:0] p, input logic [23:0] mx,
                                           input logic [23:0] mn);
    logic [23:0] r;
    for (int c = 0; c < 3; c++) begin
      logic [7:0] v;
      v = p[c*8 +: 8];
      if (v < mn[c*8 +: 8]) v = mn[c*8 +: 8];
      if (v > mx[c*8 +: 8]) v = mx[c*8 +: 8];
      r[c*8 +: 8] = v;
    end
    return r;
  endfunction

  // Present one input beat at a falling edge, then check at the next falling edge
  task automatic beat(input logic [23:0] p, input logic de, input logic hs, input logic vs);
    inPix = p; inDe = de; inHs = hs; inVs = vs;
    @(negedge clk);
  endtask

  task automatic load_limits(input logic [23:0] mx, input logic [23:0] mn);
    maxWord = mx; minWord = mn; limLoad = 1'b1;
    @(negedge clk);
    limLoad = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 pix", outPix, 0);
    check("R1 de/hs/vs", {outDe, outHs, outVs}, 0);
  endtask

  task automatic t_ycc_defaults;
    beat(24'hFF00FF, 1, 0, 0);
    check("R5 R3 R4 ycc clip", outPix, 24'hF010F0);
    beat(24'h05FF80, 1, 0, 0);
    check("R5 R3 R4 ycc mixed", outPix, 24'h10EB80);
    check("R2 de", outDe, 1);
  endtask

  task automatic t_sync_blank;
    beat(24'hABCDEF, 0, 1, 0);
    check("R8 blank pix", outPix, 0);
    check("R2 hs/vs/de", {outDe, outHs, outVs}, 3'b010);
    beat(24'hABCDEF, 0, 0, 1);
    check("R2 vs", {outDe, outHs, outVs}, 3'b001);
  endtask

  task automatic t_rgb_switch;
    ycbcrMode = 1'b0;
    @(negedge clk);
    beat(24'hFF0080, 1, 0, 0);
    check("R6 R10 rgb defaults", outPix, 24'hFE0180);
  endtask

  task automatic t_program;
    load_limits(24'hC0A0FF, 24'h204000);
    beat(24'h10FF30, 1, 0, 0);
    check("R11 R3 R4 programmed", outPix, ref_clip(24'h10FF30, 24'hC0A0FF, 24'h204000));
    maxWord = 24'h111111; minWord = 24'h000000;
    beat(24'h10FF30, 1, 0, 0);
    check("R11 words ignored without strobe", outPix, 24'h20A030);
  endtask

  task automatic t_inverted;
    load_limits(24'h404040, 24'h808080);
    beat(24'h30FF50, 1, 0, 0);
    check("R9 inverted window", outPix, 24'h404040);
  endtask

  task automatic t_full_range;
    fullRange = 1'b1;
    beat(24'hFF0001, 1, 0, 0);
    check("R7 pass through", outPix, 24'hFF0001);
    beat(24'hFF0001, 0, 0, 0);
    check("R8 blank under full range", outPix, 0);
    fullRange = 1'b0;
  endtask

  task automatic t_priority;
    ycbcrMode = 1'b1;
    load_limits(24'h909090, 24'h303030);
    beat(24'hFF00FF, 1, 0, 0);
    check("R10 load beats mode reload", outPix, 24'h903090);
    ycbcrMode = 1'b0;
    @(negedge clk);
    beat(24'hFF00FF, 1, 0, 0);
    check("R10 mode reload after load", outPix, 24'hFE01FE);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        t_reset();
        t_ycc_defaults();
        t_sync_blank();
        t_rgb_switch();
        t_program();
        t_inverted();
        t_full_range();
        t_priority();
      end
      begin
        repeat (5000) @(negedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule